// File: doc/BRIEF.md
# Page Write Load Controller

This block sits between an SRAM-style write port (active-low chip enable, output enable and write strobe) and a programmable memory array. It gathers individual byte writes into a page buffer. The first accepted byte opens a load and fixes the page. Further bytes for the same page may arrive in any order and may overwrite earlier ones. When no byte has been accepted for a programmable number of clock cycles, the load closes and a timed programming period begins.

At the end of that period the block presents the whole page on a valid/ready commit interface. The commit carries the page number, the buffered bytes and a per-byte enable mask, so the array updates only the bytes that were loaded. The commit stream obeys these back-pressure rules:
- `cmt_valid` stays high until the cycle in which `cmt_ready` is sampled high.
- While the commit waits, page, data and mask do not change.
- `busy` covers both the programming period and the wait.

All time limits are clock-cycle parameters: the load window, the programming time, the power-on write inhibit and the minimum strobe width. The control inputs are taken to be synchronous to `clk`.

Top module: `pwl_page_writer`

## Requirements
- R1: After reset, `busy` and `cmt_valid` are 0, `cmt_mask` is all zero and `last_addr` is 0.
- R2: A write strobe counts only on cycles where `ce_n`=0, `we_n`=0 and `oe_n`=1. A pulse made with `oe_n`=0 or with `ce_n`=1 loads nothing.
- R3: A strobe that is active on fewer than MIN_PULSE consecutive clock edges is ignored. A strobe is accepted on the edge after it is released, using the address from its first active cycle and the data from its last active cycle.
- R4: Strobes released before POR_CYCLES clock cycles have passed since reset are ignored.
- R5: The first accepted byte fixes the page to `addr[12:6]`. Each accepted byte is stored at offset `addr[5:0]`, and its bit in `cmt_mask` (bit n = offset n) is set. Bytes may come in any order. A repeated offset keeps the last value written.
- R6: The load closes when WIN_CYCLES clock edges pass with no accepted byte. If byte acceptance happens at edge e, `busy` rises after edge e+WIN_CYCLES.
- R7: While a load is open, a strobe whose `addr[12:6]` differs from the captured page is ignored. It does not change `last_addr` and does not restart the window.
- R8: Programming lasts PROG_CYCLES cycles. If `busy` rises after edge p, `cmt_valid` rises after edge p+PROG_CYCLES.
- R9: The commit carries `cmt_page`, `cmt_data` (byte n at bits 8n+7:8n) and `cmt_mask`, with only loaded bytes set in the mask. All three are held stable while `cmt_valid`=1 and `cmt_ready`=0.
- R10: Strobes accepted while `busy`=1 are ignored and do not alter `last_addr` or the pending commit.
- R11: `busy` and `cmt_valid` drop on the edge after a valid/ready handshake. The mask is cleared, so the next load starts empty.
- R12: `last_addr` holds the full address of the most recently accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low; must be high to write |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 13 | Byte address: page in 12:6, offset in 5:0 |
| wdata | input | 8 | Write data byte |
| busy | output | 1 | High during programming and while the commit waits |
| cmt_valid | output | 1 | Commit payload is valid |
| cmt_ready | input | 1 | Array accepts the commit |
| cmt_page | output | 7 | Page number of the commit |
| cmt_data | output | 512 | Buffered page bytes |
| cmt_mask | output | 64 | Per-byte write enable |
| last_addr | output | 13 | Address of the last accepted byte |

## Verification
The assertions take two things for granted:
- The strobe, address and data inputs change only between clock edges, so the pulse filter sees a clean width count.
- `cmt_ready` is driven as a level by the array side, with no assumption about how long it stays low.

The stimulus changes every input at the falling clock edge and holds each strobe for whole cycles. It keeps `cmt_ready` low for several cycles before a handshake, so the hold rule of the commit is exercised. Gaps between bytes within a load stay well inside the window, except where the window expiry itself is measured.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_PROG   = 2'd2,
    ST_COMMIT = 2'd3
  } pwl_state_e;
endpackage

// File: rtl/pwl_strobe_filter.sv
module pwl_strobe_filter #(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int MIN_PULSE  = 1,
  parameter int POR_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              evt,
  output logic [ADDR_W-1:0] evt_addr,
  output logic [DATA_W-1:0] evt_data
);
  localparam int WID_W = $clog2(MIN_PULSE + 1);
  localparam int POR_W = $clog2(POR_CYCLES + 1);

  logic              strobe_on;
  logic              on_q;
  logic [WID_W-1:0]  wid;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [POR_W-1:0]  por_cnt;
  logic              por_done;

  assign strobe_on = !ce_n && !we_n && oe_n;
  assign por_done  = (por_cnt == POR_W'(POR_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) por_cnt <= '0;
    else if (!por_done) por_cnt <= por_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q     <= 1'b0;
      wid      <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      evt      <= 1'b0;
      evt_addr <= '0;
      evt_data <= '0;
    end else begin
      on_q <= strobe_on;
      evt  <= 1'b0;
      if (strobe_on) begin
        data_q <= wdata;
        if (!on_q) begin
          addr_q <= addr;
          wid    <= WID_W'(1);
        end else if (wid != WID_W'(MIN_PULSE)) begin
          wid <= wid + 1'b1;
        end
      end else if (on_q) begin
        evt      <= por_done && (wid >= WID_W'(MIN_PULSE));
        evt_addr <= addr_q;
        evt_data <= data_q;
      end
    end
  end

  assert_evt_after_por_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> por_done);
  assert_evt_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
endmodule

// File: rtl/pwl_page_buffer.sv
module pwl_page_buffer #(
  parameter int PAGE_BYTES = 64,
  parameter int DATA_W     = 8,
  localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [OFS_W-1:0]             wr_ofs,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         clr,
  output logic [PAGE_BYTES*DATA_W-1:0] buf_data,
  output logic [PAGE_BYTES-1:0]        buf_mask
);
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        buf_mask[g]                 <= 1'b0;
        buf_data[g*DATA_W +: DATA_W] <= '0;
      end else if (clr) begin
        buf_mask[g] <= 1'b0;
      end else if (wr_en && (wr_ofs == OFS_W'(g))) begin
        buf_mask[g]                 <= 1'b1;
        buf_data[g*DATA_W +: DATA_W] <= wr_data;
      end
    end
  end

  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (buf_mask == '0));
  assert_byte_marked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> buf_mask[$past(wr_ofs)]);
endmodule

// File: rtl/pwl_load_seq.sv
module pwl_load_seq
  import pwl_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int OFS_W       = 6,
  parameter int WIN_CYCLES  = 7500,
  parameter int PROG_CYCLES = 500000,
  localparam int PAGE_W     = ADDR_W - OFS_W,
  localparam int MAX_T      = (WIN_CYCLES > PROG_CYCLES) ? WIN_CYCLES : PROG_CYCLES,
  localparam int CNT_W      = $clog2(MAX_T + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [DATA_W-1:0] evt_data,
  input  logic              cmt_ready,
  output logic              buf_we,
  output logic [OFS_W-1:0]  buf_ofs,
  output logic [DATA_W-1:0] buf_wdata,
  output logic              buf_clr,
  output logic [PAGE_W-1:0] page_q,
  output logic [ADDR_W-1:0] last_addr,
  output logic              busy,
  output logic              cmt_valid
);
  pwl_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             same_page;

  assign same_page = (evt_addr[ADDR_W-1:OFS_W] == page_q);
  assign buf_we    = evt && ((state == ST_IDLE) || ((state == ST_LOAD) && same_page));
  assign buf_ofs   = evt_addr[OFS_W-1:0];
  assign buf_wdata = evt_data;
  assign busy      = (state == ST_PROG) || (state == ST_COMMIT);
  assign cmt_valid = (state == ST_COMMIT);
  assign buf_clr   = cmt_valid && cmt_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      page_q    <= '0;
      last_addr <= '0;
    end else begin
      if (buf_we) last_addr <= evt_addr;
      unique case (state)
        ST_IDLE: if (buf_we) begin
          page_q <= evt_addr[ADDR_W-1:OFS_W];
          cnt    <= '0;
          state  <= ST_LOAD;
        end
        ST_LOAD: begin
          if (buf_we) cnt <= '0;
          else if (cnt == CNT_W'(WIN_CYCLES - 1)) begin
            cnt   <= '0;
            state <= ST_PROG;
          end else cnt <= cnt + 1'b1;
        end
        ST_PROG: begin
          if (cnt == CNT_W'(PROG_CYCLES - 1)) begin
            cnt   <= '0;
            state <= ST_COMMIT;
          end else cnt <= cnt + 1'b1;
        end
        ST_COMMIT: if (cmt_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_page_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD) |=> $stable(page_q));
  assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(last_addr));
  assert_busy_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && cmt_ready) |=> (!busy && !cmt_valid));
  assert_page_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && !cmt_ready) |=> (cmt_valid && $stable(page_q)));
endmodule

// File: rtl/pwl_page_writer.sv
module pwl_page_writer #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 64,
  parameter int WIN_CYCLES  = 7500,
  parameter int PROG_CYCLES = 500000,
  parameter int POR_CYCLES  = 250000,
  parameter int MIN_PULSE   = 1,
  localparam int OFS_W      = $clog2(PAGE_BYTES),
  localparam int PAGE_W     = ADDR_W - OFS_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ce_n,
  input  logic                         oe_n,
  input  logic                         we_n,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic                         busy,
  output logic                         cmt_valid,
  input  logic                         cmt_ready,
  output logic [PAGE_W-1:0]            cmt_page,
  output logic [PAGE_BYTES*DATA_W-1:0] cmt_data,
  output logic [PAGE_BYTES-1:0]        cmt_mask,
  output logic [ADDR_W-1:0]            last_addr
);
  logic              evt;
  logic [ADDR_W-1:0] evt_addr;
  logic [DATA_W-1:0] evt_data;
  logic              buf_we;
  logic [OFS_W-1:0]  buf_ofs;
  logic [DATA_W-1:0] buf_wdata;
  logic              buf_clr;

  pwl_strobe_filter #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE), .POR_CYCLES(POR_CYCLES)
  ) u_filter (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata),
    .evt(evt), .evt_addr(evt_addr), .evt_data(evt_data)
  );

  pwl_load_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W),
    .WIN_CYCLES(WIN_CYCLES), .PROG_CYCLES(PROG_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .evt(evt), .evt_addr(evt_addr), .evt_data(evt_data),
    .cmt_ready(cmt_ready), .buf_we(buf_we), .buf_ofs(buf_ofs), .buf_wdata(buf_wdata),
    .buf_clr(buf_clr), .page_q(cmt_page), .last_addr(last_addr), .busy(busy),
    .cmt_valid(cmt_valid)
  );

  pwl_page_buffer #(
    .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(buf_we), .wr_ofs(buf_ofs), .wr_data(buf_wdata),
    .clr(buf_clr), .buf_data(cmt_data), .buf_mask(cmt_mask)
  );

  assert_payload_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && !cmt_ready) |=> ($stable(cmt_mask) && $stable(cmt_data)));
  assert_mask_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> ($countones(cmt_mask) > 0));
endmodule

// File: tb/sim_pwl_page_writer.sv
module sim_pwl_page_writer;
  localparam int WIN  = 20;
  localparam int PROG = 30;
  localparam int POR  = 16;
  localparam int MINP = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [12:0]  addr = '0;
  logic [7:0]   wdata = '0;
  logic         cmt_ready = 1'b0;
  logic         busy, cmt_valid;
  logic [6:0]   cmt_page;
  logic [511:0] cmt_data;
  logic [63:0]  cmt_mask;
  logic [12:0]  last_addr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ev_cyc = 0;

  // {foreign page flag, address, data}
  localparam logic [21:0] VEC [8] = '{
    {1'b0, 13'h0AC5, 8'h11},
    {1'b0, 13'h0AC0, 8'h22},
    {1'b0, 13'h0AFF, 8'h33},
    {1'b0, 13'h0AC5, 8'h44},
    {1'b1, 13'h0B05, 8'h55},
    {1'b0, 13'h0AE1, 8'h66},
    {1'b0, 13'h0AC9, 8'h77},
    {1'b1, 13'h0005, 8'h88}
  };

  logic [7:0]  exp_data [64];
  logic [63:0] exp_mask;
  logic [12:0] exp_last;

  pwl_page_writer #(
    .WIN_CYCLES(WIN), .PROG_CYCLES(PROG), .POR_CYCLES(POR), .MIN_PULSE(MINP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .busy(busy), .cmt_valid(cmt_valid),
    .cmt_ready(cmt_ready), .cmt_page(cmt_page), .cmt_data(cmt_data),
    .cmt_mask(cmt_mask), .last_addr(last_addr)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d, input int width,
                    input logic oe_v, input logic ce_v);
    @(negedge clk);
    addr = a; wdata = d; ce_n = ce_v; oe_n = oe_v; we_n = 1'b0;
    repeat (width) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    repeat (2) @(negedge clk);
    ev_cyc = cyc;
  endtask

  task automatic wait_to(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic handshake();
    repeat (3) @(negedge clk);
    chk(cmt_valid == 1'b1, "R9 valid held", 64'(cmt_valid), 64'd1);
    chk(cmt_mask == exp_mask, "R9 mask held", cmt_mask, exp_mask);
    cmt_ready = 1'b1;
    @(negedge clk);
    cmt_ready = 1'b0;
    chk(busy == 1'b0, "R11 busy dropped", 64'(busy), 64'd0);
    chk(cmt_valid == 1'b0, "R11 valid dropped", 64'(cmt_valid), 64'd0);
    chk(cmt_mask == 64'd0, "R11 mask cleared", cmt_mask, 64'd0);
  endtask

  task automatic check_timing(input string tag);
    int p;
    wait_to(ev_cyc + WIN - 1);
    chk(busy == 1'b0, {tag, " R6 open before window end"}, 64'(busy), 64'd0);
    wait_to(ev_cyc + WIN);
    chk(busy == 1'b1, {tag, " R6 busy at window end"}, 64'(busy), 64'd1);
    p = ev_cyc + WIN;
    wait_to(p + PROG - 1);
    chk(cmt_valid == 1'b0, {tag, " R8 no commit early"}, 64'(cmt_valid), 64'd0);
    wait_to(p + PROG);
    chk(cmt_valid == 1'b1, {tag, " R8 commit after programming"}, 64'(cmt_valid), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && cmt_valid == 1'b0, "R1 reset outputs",
        64'({busy, cmt_valid}), 64'd0);
    chk(cmt_mask == 64'd0, "R1 reset mask", cmt_mask, 64'd0);
    chk(last_addr == 13'd0, "R1 reset last_addr", 64'(last_addr), 64'd0);
    rst_n = 1'b1;

    // R4: write inside the power-on delay
    wr(13'h0101, 8'hEE, 3, 1'b1, 1'b0);
    repeat (WIN + 4) @(negedge clk);
    chk(busy == 1'b0, "R4 no load during power-on", 64'(busy), 64'd0);
    chk(last_addr == 13'd0, "R4 last_addr untouched", 64'(last_addr), 64'd0);

    // R2: output enable low, chip enable high
    wr(13'h0102, 8'hE1, 3, 1'b0, 1'b0);
    wr(13'h0103, 8'hE2, 3, 1'b1, 1'b1);
    repeat (WIN + 4) @(negedge clk);
    chk(busy == 1'b0 && last_addr == 13'd0, "R2 inhibited strobes",
        64'({busy, last_addr}), 64'd0);

    // R3: short pulse
    wr(13'h0104, 8'hE3, 1, 1'b1, 1'b0);
    repeat (WIN + 4) @(negedge clk);
    chk(busy == 1'b0 && last_addr == 13'd0, "R3 short pulse ignored",
        64'({busy, last_addr}), 64'd0);

    // Table-driven load: R5 R7 R12
    exp_mask = '0;
    exp_last = '0;
    for (int k = 0; k < 64; k++) exp_data[k] = '0;
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][20:8], VEC[i][7:0], MINP, 1'b1, 1'b0);
      if (!VEC[i][21]) begin
        exp_last = VEC[i][20:8];
        exp_mask[VEC[i][13:8]] = 1'b1;
        exp_data[VEC[i][13:8]] = VEC[i][7:0];
      end
      chk(last_addr == exp_last, "R12/R7 last_addr after vector",
          64'(last_addr), 64'(exp_last));
      if (!VEC[i][21]) chk(busy == 1'b0, "R6 load stays open", 64'(busy), 64'd0);
    end
    // last accepted byte in table is entry 6; foreign entry 7 must not restart window
    ev_cyc = ev_cyc - 5;
    check_timing("table");
    chk(cmt_page == 7'h2B, "R5 page captured", 64'(cmt_page), 64'h2B);
    chk(cmt_mask == exp_mask, "R9 loaded bytes only", cmt_mask, exp_mask);
    for (int k = 0; k < 64; k++)
      if (exp_mask[k])
        chk(cmt_data[k*8 +: 8] == exp_data[k], "R5 byte value",
            64'(cmt_data[k*8 +: 8]), 64'(exp_data[k]));
    handshake();

    // R10: strobe during programming
    wr(13'h0123, 8'hA5, 2, 1'b1, 1'b0);
    exp_mask = 64'd1 << 6'h23;
    wait_to(ev_cyc + WIN + 1);
    wr(13'h0124, 8'h5A, 2, 1'b1, 1'b0);
    chk(last_addr == 13'h0123, "R10 busy strobe ignored", 64'(last_addr), 64'h0123);
    while (!cmt_valid) @(negedge clk);
    chk(cmt_mask == exp_mask, "R10 mask unchanged", cmt_mask, exp_mask);
    chk(cmt_data[8'h23*8 +: 8] == 8'hA5, "R10 data", 64'(cmt_data[8'h23*8 +: 8]), 64'hA5);
    chk(cmt_page == 7'h04, "R5 page of second load", 64'(cmt_page), 64'h04);
    handshake();

    // R7: foreign page does not restart window
    wr(13'h0200, 8'h01, 2, 1'b1, 1'b0);
    begin
      int e0;
      e0 = ev_cyc;
      wr(13'h0400, 8'h02, 2, 1'b1, 1'b0);
      chk(last_addr == 13'h0200, "R7 foreign ignored", 64'(last_addr), 64'h0200);
      ev_cyc = e0;
    end
    exp_mask = 64'd1;
    check_timing("foreign");
    chk(cmt_mask == 64'd1, "R7 mask single byte", cmt_mask, 64'd1);
    handshake();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule